// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block is the transmit half of an asynchronous serial port. The host writes a byte into a holding register. When the shift engine is free, that byte is moved into it and sent on a single line. Each character is sent as a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or more high stop bits. The baud rate comes from an external tick that pulses at 16 times the bit rate. Each bit lasts 16 of these ticks.

The host sets the character format through a small set of field inputs: word length, stop-bit length, parity enable and parity sense. The format is captured when a byte enters the shift engine, so a format change cannot corrupt a character that is already being sent.

A break control holds the line low for as long as it is set. Two status flags report progress:
- `thre` tells the host that the holding register can take another byte.
- `tsre` reports that the whole transmitter has gone quiet.

A byte written while a character is being shifted waits in the holding register. It follows the current character with no idle time between them.

Top module: `serial_fmt_tx`

## Requirements
- R1: `fmt_wlen` codes 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Only bits `wr_data[n-1:0]` of the byte are sent.
- R2: The line idles high. A frame begins with one low start bit, followed by the data bits with bit 0 first. Every start, data and parity bit lasts 16 `baud_tick` pulses.
- R3: When `fmt_par_en` is 1, a parity bit follows the last data bit. With `fmt_par_even`=1 the count of ones over the sent data bits plus the parity bit is even. With `fmt_par_even`=0 that count is odd. Unsent data bits do not count.
- R4: The stop level is high. With `fmt_stop_long`=0 it lasts 16 ticks. With `fmt_stop_long`=1 it lasts 24 ticks for 5-bit words and 32 ticks for all other word lengths.
- R5: A byte that is waiting in the holding register starts on the tick that ends the previous stop period. The start-to-start spacing of such frames is therefore exactly 16·(1+n+p)+stop ticks, where n is the number of data bits and p is 1 if parity is on.
- R6: `thre` goes to 0 on the clock edge that captures `wr_en`. From an idle transmitter, the byte moves into the shift engine on the next edge, which sets `thre` again, and `txd` falls one edge after that. A write to a full holding register replaces the waiting byte.
- R7: `tsre` is 1 only when the shift engine is idle and the holding register is empty. It stays 0 between back-to-back frames. It rises on the edge where the final stop period ends.
- R8: `fmt_break`=1 drives `txd` low from the next clock edge until one edge after it clears. Shifting continues underneath, so `thre` and `tsre` still advance.
- R9: If a write lands on the same edge as a transfer into the shift engine, the old byte is sent, the new byte is held, and `thre` stays 0.
- R10: After reset, `txd`=1, `thre`=1 and `tsre`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| fmt_wlen | input | 2 | Word length code |
| fmt_stop_long | input | 1 | Long stop period select |
| fmt_par_en | input | 1 | Parity bit enable |
| fmt_par_even | input | 1 | 1 = even parity, 0 = odd |
| fmt_break | input | 1 | Force the line low |
| txd | output | 1 | Serial output line |
| thre | output | 1 | Holding register empty |
| tsre | output | 1 | Holding register and shift engine both empty |

## Verification
Two functions can fall on the same clock edge: a host write into the holding register, and the transfer of the holding register into the shift engine. The bench provokes this in two ways.
- It strobes `wr_en` on two consecutive edges while the transmitter is idle, so the second write meets the transfer caused by the first. The check is that `thre` stays low and that both bytes appear on the line in order.
- Across a sweep of all 32 format combinations, it writes each follow-on byte as soon as `thre` rises. This places the end-of-stop transfer next to host activity, and the bench judges the exact start-to-start spacing and the cycle at which `tsre` rises.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // shift engine phases
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] data_q,
  output logic          full_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_en) begin
        data_q <= wr_data;
      end
      if (wr_en) begin
        full_q <= 1'b1;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  // R6
  hold_fill_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> $past(wr_en));

  // R9
  hold_keep_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> full_q);

endmodule

// File: rtl/sertx_fmt.sv
module sertx_fmt #(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int NB_W = $clog2(DW) + 1,
  localparam int ST_W = $clog2(2 * OVS) + 1
) (
  input  logic [1:0]      wlen,
  input  logic            stop_long,
  input  logic            par_even,
  input  logic [DW-1:0]   data,
  output logic [NB_W-1:0] nbits,
  output logic [ST_W-1:0] stop_ticks,
  output logic            par_bit
);

  localparam int MIN_BITS = DW - 3;

  logic [DW-1:0] sel;

  assign nbits = NB_W'(MIN_BITS + int'(wlen));

  // only the configured data bits take part in parity
  for (genvar g = 0; g < DW; g++) begin : g_sel
    assign sel[g] = data[g] & (g < int'(nbits));
  end

  assign par_bit = (^sel) ^ ~par_even;

  always_comb begin
    if (!stop_long) begin
      stop_ticks = ST_W'(OVS);
    end else if (int'(nbits) == MIN_BITS) begin
      stop_ticks = ST_W'(OVS + OVS / 2);
    end else begin
      stop_ticks = ST_W'(2 * OVS);
    end
  end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16,
  localparam int NB_W  = $clog2(DW) + 1,
  localparam int ST_W  = $clog2(2 * OVS) + 1,
  localparam int CNT_W = $clog2(2 * OVS),
  localparam int IDX_W = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            load,
  input  logic [DW-1:0]   load_data,
  input  logic [NB_W-1:0] nbits_in,
  input  logic [ST_W-1:0] stop_in,
  input  logic            par_en_in,
  input  logic            par_bit_in,
  output logic            line_q,
  output logic            idle,
  output logic            take_ok
);

  tx_state_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [IDX_W-1:0] idx, idx_n;
  logic [DW-1:0]    sh, sh_n;
  logic             par_q, par_n;
  logic             pen_q, pen_n;
  logic [NB_W-1:0]  nb_q, nb_n;
  logic [ST_W-1:0]  stp_q, stp_n;
  logic             line_n;

  logic bit_end, stop_end, last_bit;

  assign bit_end  = tick && (cnt == CNT_W'(OVS - 1));
  assign stop_end = (st == ST_STOP) && tick && ({1'b0, cnt} == stp_q - 1'b1);
  assign last_bit = ({1'b0, idx} == nb_q - 1'b1);
  assign take_ok  = (st == ST_IDLE) || stop_end;
  assign idle     = (st == ST_IDLE);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    idx_n  = idx;
    sh_n   = sh;
    par_n  = par_q;
    pen_n  = pen_q;
    nb_n   = nb_q;
    stp_n  = stp_q;
    line_n = line_q;
    if (load) begin
      st_n   = ST_START;
      cnt_n  = '0;
      idx_n  = '0;
      sh_n   = load_data;
      par_n  = par_bit_in;
      pen_n  = par_en_in;
      nb_n   = nbits_in;
      stp_n  = stop_in;
      line_n = 1'b0;
    end else if (tick) begin
      unique case (st)
        ST_IDLE: begin
          line_n = 1'b1;
        end
        ST_START: begin
          if (bit_end) begin
            st_n   = ST_DATA;
            cnt_n  = '0;
            line_n = sh[0];
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_n = '0;
            if (last_bit) begin
              st_n   = pen_q ? ST_PAR : ST_STOP;
              line_n = pen_q ? par_q : 1'b1;
            end else begin
              idx_n  = idx + 1'b1;
              line_n = sh[1];
              sh_n   = sh >> 1;
            end
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_end) begin
            st_n   = ST_STOP;
            cnt_n  = '0;
            line_n = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (stop_end) begin
            st_n   = ST_IDLE;
            cnt_n  = '0;
            line_n = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        default: begin
          st_n   = ST_IDLE;
          line_n = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      par_q  <= 1'b0;
      pen_q  <= 1'b0;
      nb_q   <= NB_W'(DW);
      stp_q  <= ST_W'(OVS);
      line_q <= 1'b1;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      idx    <= idx_n;
      sh     <= sh_n;
      par_q  <= par_n;
      pen_q  <= pen_n;
      nb_q   <= nb_n;
      stp_q  <= stp_n;
      line_q <= line_n;
    end
  end

  // R2
  line_high_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE || st == ST_STOP) |-> line_q);

  // R4
  stop_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} < stp_q);

  // R5
  start_from_load_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && $past(st) != ST_START) |-> $past(load));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START) |-> !line_q);

endmodule

// File: rtl/serial_fmt_tx.sv
module serial_fmt_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    fmt_wlen,
  input  logic          fmt_stop_long,
  input  logic          fmt_par_en,
  input  logic          fmt_par_even,
  input  logic          fmt_break,
  output logic          txd,
  output logic          thre,
  output logic          tsre
);

  localparam int NB_W = $clog2(DW) + 1;
  localparam int ST_W = $clog2(2 * OVS) + 1;

  logic [DW-1:0]   hold_data;
  logic            hold_full;
  logic            take_ok;
  logic            load;
  logic            sh_idle;
  logic            line_lvl;
  logic [NB_W-1:0] nbits;
  logic [ST_W-1:0] stop_ticks;
  logic            par_bit;
  logic            txd_q;

  assign load = take_ok & hold_full;

  sertx_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (load),
    .data_q  (hold_data),
    .full_q  (hold_full)
  );

  sertx_fmt #(.DW(DW), .OVS(OVS)) u_fmt (
    .wlen       (fmt_wlen),
    .stop_long  (fmt_stop_long),
    .par_even   (fmt_par_even),
    .data       (hold_data),
    .nbits      (nbits),
    .stop_ticks (stop_ticks),
    .par_bit    (par_bit)
  );

  sertx_shift #(.DW(DW), .OVS(OVS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .tick       (baud_tick),
    .load       (load),
    .load_data  (hold_data),
    .nbits_in   (nbits),
    .stop_in    (stop_ticks),
    .par_en_in  (fmt_par_en),
    .par_bit_in (par_bit),
    .line_q     (line_lvl),
    .idle       (sh_idle),
    .take_ok    (take_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_q <= 1'b1;
    end else begin
      txd_q <= line_lvl & ~fmt_break;
    end
  end

  assign txd  = txd_q;
  assign thre = ~hold_full;
  assign tsre = sh_idle & ~hold_full;

  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_break |=> !txd);

  // R7
  tsre_low_on_transfer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(thre) |-> !tsre);

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (txd && thre && tsre));

endmodule

// File: tb/tb_serial_fmt_tx.sv
module tb_serial_fmt_tx;

  localparam int TPER = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] fmt_wlen = 2'b11;
  logic       fmt_stop_long = 1'b0;
  logic       fmt_par_en = 1'b0;
  logic       fmt_par_even = 1'b0;
  logic       fmt_break = 1'b0;
  logic       txd, thre, tsre;

  serial_fmt_tx dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .fmt_wlen(fmt_wlen), .fmt_stop_long(fmt_stop_long),
    .fmt_par_en(fmt_par_en), .fmt_par_even(fmt_par_even),
    .fmt_break(fmt_break), .txd(txd), .thre(thre), .tsre(tsre)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected format, set by the driver while the line is idle
  int e_n = 8, e_pen = 0, e_even = 0, e_stopt = 16;
  bit mon_en = 1'b1;
  int rx_n = 0;
  logic [7:0] rx_data [8];
  int rx_start [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_ticks();
    return 16 * (1 + e_n + e_pen) + e_stopt;
  endfunction

  function automatic logic [7:0] mask_of(input int n);
    return 8'((1 << n) - 1);
  endfunction

  task automatic set_fmt(input int c);
    fmt_wlen      = c[1:0];
    fmt_stop_long = c[2];
    fmt_par_en    = c[3];
    fmt_par_even  = c[4];
    e_n    = 5 + c[1:0];
    e_pen  = c[3];
    e_even = c[4];
    e_stopt = c[2] ? ((e_n == 5) ? 24 : 32) : 16;
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_thre();
    while (!thre) @(negedge clk);
  endtask

  task automatic wait_tsre();
    while (!tsre) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    while (rx_n < n) @(negedge clk);
  endtask

  // baud tick generator
  initial begin
    forever begin
      repeat (TPER - 1) @(negedge clk);
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
    end
  end

  // line monitor: decodes frames with the expected format
  task automatic sample_at(input int t0, input int off);
    while (cyc < t0 + off * TPER) @(negedge clk);
  endtask

  initial begin
    int t0, s;
    logic [7:0] d;
    forever begin
      @(negedge clk);
      if (mon_en && !rst && txd === 1'b0) begin
        t0 = cyc;
        d = 8'h00;
        sample_at(t0, 8);
        chk(txd == 1'b0, "R2 start bit level", int'(txd), 0);
        for (int k = 0; k < e_n; k++) begin
          sample_at(t0, 16 * (k + 1) + 8);
          d[k] = txd;
        end
        s = 1 + e_n;
        if (e_pen != 0) begin
          sample_at(t0, 16 * s + 8);
          chk(txd == ((^d) ^ (e_even == 0)), "R3 parity bit", int'(txd),
              int'((^d) ^ (e_even == 0)));
          s++;
        end
        sample_at(t0, 16 * s + 8);
        chk(txd == 1'b1, "R4 stop level", int'(txd), 1);
        if (e_stopt == 24) begin
          sample_at(t0, 16 * s + 18);
          chk(txd == 1'b1, "R4 half stop level", int'(txd), 1);
        end else if (e_stopt == 32) begin
          sample_at(t0, 16 * s + 24);
          chk(txd == 1'b1, "R4 second stop level", int'(txd), 1);
        end
        if (rx_n < 8) begin
          rx_data[rx_n] = d;
          rx_start[rx_n] = t0;
          rx_n = rx_n + 1;
        end
        sample_at(t0, frame_ticks() - 2);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
  end

  initial begin
    int ft, t_ts, highs;
    logic [7:0] b [3];

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(txd == 1'b1, "R10 reset txd", int'(txd), 1);
    chk(thre == 1'b1, "R10 reset thre", int'(thre), 1);
    chk(tsre == 1'b1, "R10 reset tsre", int'(tsre), 1);

    // R6 latency from idle
    set_fmt(3);
    rx_n = 0;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'hA5;
    @(negedge clk);
    wr_en = 1'b0;
    chk(thre == 1'b0, "R6 thre clears after write", int'(thre), 0);
    chk(txd == 1'b1, "R6 txd still idle", int'(txd), 1);
    @(negedge clk);
    chk(thre == 1'b1, "R6 thre set on transfer", int'(thre), 1);
    chk(tsre == 1'b0, "R7 tsre low while shifting", int'(tsre), 0);
    @(negedge clk);
    chk(txd == 1'b0, "R6 start bit two edges after write", int'(txd), 0);
    wait_tsre();
    wait_rx(1);
    chk(rx_data[0] == 8'hA5, "R2 lsb-first data", int'(rx_data[0]), 'hA5);

    // R9 write on the transfer edge
    repeat (8) @(negedge clk);
    rx_n = 0;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 8'h3C;
    @(negedge clk);
    wr_data = 8'hC6;
    @(negedge clk);
    wr_en = 1'b0;
    chk(thre == 1'b0, "R9 thre stays low", int'(thre), 0);
    wait_tsre();
    wait_rx(2);
    chk(rx_data[0] == 8'h3C, "R9 old byte sent first", int'(rx_data[0]), 'h3C);
    chk(rx_data[1] == 8'hC6, "R9 new byte sent second", int'(rx_data[1]), 'hC6);

    // R6 overwrite of a waiting byte
    repeat (8) @(negedge clk);
    rx_n = 0;
    write_byte(8'h11);
    repeat (3) @(negedge clk);
    write_byte(8'h22);
    repeat (3) @(negedge clk);
    write_byte(8'h33);
    wait_tsre();
    repeat (20) @(negedge clk);
    chk(rx_n == 2, "R6 frame count after overwrite", rx_n, 2);
    chk(rx_data[0] == 8'h11, "R6 first byte", int'(rx_data[0]), 'h11);
    chk(rx_data[1] == 8'h33, "R6 latest waiting byte", int'(rx_data[1]), 'h33);

    // R8 break, idle and during a frame
    mon_en = 1'b0;
    @(negedge clk);
    fmt_break = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R8 break forces low", int'(txd), 0);
    write_byte(8'hFF);
    @(negedge clk);
    chk(thre == 1'b1, "R8 transfer under break", int'(thre), 1);
    highs = 0;
    while (!tsre) begin
      @(negedge clk);
      if (txd) highs++;
    end
    chk(highs == 0, "R8 line held low through frame", highs, 0);
    chk(tsre == 1'b1, "R8 shifting completes under break", int'(tsre), 1);
    fmt_break = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R8 release returns high", int'(txd), 1);
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    // format sweep with back-to-back frames
    for (int c = 0; c < 32; c++) begin
      set_fmt(c);
      ft = frame_ticks();
      b[0] = 8'(c * 37 + 5);
      b[1] = ~b[0];
      b[2] = b[0] ^ 8'h5A;
      repeat (4) @(negedge clk);
      rx_n = 0;
      write_byte(b[0]);
      wait_thre();
      write_byte(b[1]);
      wait_thre();
      write_byte(b[2]);
      wait_tsre();
      t_ts = cyc;
      wait_rx(3);
      for (int i = 0; i < 3; i++) begin
        chk(rx_data[i] == (b[i] & mask_of(e_n)), $sformatf("R1 data cfg %0d", c),
            int'(rx_data[i]), int'(b[i] & mask_of(e_n)));
      end
      chk(rx_start[2] - rx_start[1] == ft * TPER,
          $sformatf("R5 R4 frame spacing cfg %0d", c),
          rx_start[2] - rx_start[1], ft * TPER);
      chk(t_ts == rx_start[2] - 1 + ft * TPER,
          $sformatf("R7 tsre rise cfg %0d", c), t_ts, rx_start[2] - 1 + ft * TPER);
    end

    repeat (10) @(negedge clk);
    summary();
  end

endmodule